// File: doc/BRIEF.md
# Texture Level-of-Detail Calculator

This block turns a per-pixel level-of-detail number into the controls a mip-mapped texture unit needs. The number arrives in signed fixed point. The block limits it to a legal range and finds the mip level as the floor of its base-two logarithm. It then works out how far the value sits between that level and the next one, as an 8-bit blend weight. It also raises flags for magnification and for reaching the coarsest allowed level. From these it picks the tile to sample: the primitive's base tile plus the chosen level, wrapping within eight tiles.

Two rendering modes change the blend weight. In the sharpen mode and in the detail mode the weight passes through unchanged. In the sharpen mode under magnification the weight is negated. The block also carries two timing helpers for two-cycle rendering: the load strobe delayed by three and by four clocks, and a phase signal that restarts at the start of each span and then alternates every clock.

Top module: `lod_calc_top`

## Requirements
- R1: `lod_in` is a 17-bit two's-complement number with 5 fractional bits, so 1.0 is 0x20 and 256.0 is 0x2000. Any value above 0x7fff is limited to 0x7fff. Otherwise, a negative value, or a value below `min_level` (15-bit unsigned, same format), is replaced by `min_level`. Every later result uses this limited value V.
- R2: The level index I is floor(log2(V)) for V of at least 1.0, and 0 below that. With `lod_en` high, `tile_out` is (`prim_tile` + L) mod 8, where L is the selected level.
- R3: The coarse flag is set when V >= 256.0 or I >= `max_level`. L is `max_level` when the coarse flag is set, and I otherwise.
- R4: The raw weight is (V / 2^I - 1.0) taken in units of 1/256 and truncated to 8 bits. Below 1.0 this is V*8 mod 256.
- R5: With `sharpen_en` and `detail_en` both low, the weight becomes 0x00 when V < 1.0. It becomes 0xff when the coarse flag is set. When both conditions hold, the coarse flag wins and the weight is 0xff.
- R6: With `sharpen_en` high and V < 1.0, `frac_out` is the two's-complement negation (mod 256) of the weight.
- R7: With `lod_en` low, `tile_out` equals `prim_tile`.
- R8: `lod_ge_one` is high exactly when V >= 1.0.
- R9: `load_d3` and `load_d4` repeat `load` exactly 3 and 4 clocks later.
- R10: `cycle` is low on the clock after `span_start`. Otherwise it inverts on every clock while `two_cycle` is high, and goes low on the clock after `two_cycle` is low.
- R11: `tile_out`, `frac_out` and `lod_ge_one` reflect the inputs sampled two rising edges earlier. A new input set can be accepted every clock.
- R12: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lod_in | input | 17 | Signed level of detail, 5 fractional bits |
| min_level | input | 15 | Lower limit for the level of detail, same format |
| max_level | input | 3 | Coarsest allowed mip level |
| prim_tile | input | 3 | Base tile of the primitive |
| lod_en | input | 1 | Add the selected level to the base tile |
| sharpen_en | input | 1 | Sharpen mode |
| detail_en | input | 1 | Detail mode |
| load | input | 1 | Load strobe to be delayed |
| span_start | input | 1 | Start of a span; restarts the phase |
| two_cycle | input | 1 | Two-cycle mode; enables phase toggling |
| tile_out | output | 3 | Selected tile |
| frac_out | output | 8 | Blend weight between levels |
| lod_ge_one | output | 1 | Limited level of detail is at least 1.0 |
| load_d3 | output | 1 | Load strobe delayed 3 clocks |
| load_d4 | output | 1 | Load strobe delayed 4 clocks |
| cycle | output | 1 | Two-cycle phase |

## Verification
The hardest case to reach is the one where the magnification and coarse-level conditions hold together. With neither mode enabled, this decides which forced weight wins. It only occurs when `max_level` is 0 and the limited value is below 1.0, including negative inputs that get replaced by a small `min_level`. The stimulus reaches it by sweeping the whole signed input range under eight configurations, one of which sets `max_level` to 0 with both modes off. The sweep streams a new value every clock, so the two-stage latency and the strobe histories are checked under back-to-back traffic. Pseudo-random load and span pulses run alongside the sweep.

// File: rtl/lod_pkg.sv
`timescale 1ns/1ps
package lod_pkg;
    localparam int LOD_W      = 17;
    localparam int FRAC_BITS  = 5;
    localparam int VAL_W      = LOD_W - 2;
    localparam int POS_W      = $clog2(VAL_W);
    localparam int IDX_W      = POS_W;
    localparam int LVL_W      = 3;
    localparam int WGT_W      = 8;
    localparam int TAP_EARLY  = 3;
    localparam int TAP_LATE   = 4;
    localparam int MAG_LOG2   = 8;

    localparam logic [VAL_W-1:0] ONE_VAL   = VAL_W'(1) << FRAC_BITS;
    localparam logic [VAL_W-1:0] MAG_LIMIT = VAL_W'(1) << (FRAC_BITS + MAG_LOG2);

    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic [POS_W-1:0] pos;
        logic [LVL_W-1:0] idx;
        logic             min_f;
        logic             max_f;
        logic [LVL_W-1:0] lvl;
        logic [LVL_W-1:0] prim;
        logic             lod_en;
        logic             sharp;
        logic             det;
    } stage1_t;

    typedef struct packed {
        logic [LVL_W-1:0] tile;
        logic [WGT_W-1:0] frac;
        logic             ge1;
    } result_t;

    typedef struct packed {
        logic [TAP_LATE-1:0] sr;
        logic                cyc;
    } strobe_t;
endpackage

// File: rtl/lod_clamp_norm.sv
`timescale 1ns/1ps
module lod_clamp_norm
    import lod_pkg::*;
(
    input  logic [LOD_W-1:0] lod_in,
    input  logic [VAL_W-1:0] min_level,
    output logic [VAL_W-1:0] val_o,
    output logic [POS_W-1:0] pos_o
);
    logic sign_bit;
    logic over_bit;

    always_comb begin
        sign_bit = lod_in[LOD_W-1];
        over_bit = lod_in[LOD_W-2];
        if (!sign_bit && over_bit) begin
            val_o = '1;
        end else if (sign_bit || (lod_in[VAL_W-1:0] < min_level)) begin
            val_o = min_level;
        end else begin
            val_o = lod_in[VAL_W-1:0];
        end
    end

    // leading-one position, highest set bit wins
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < VAL_W; i++) begin
            if (val_o[i]) pos_o = POS_W'(i);
        end
    end
endmodule

// File: rtl/lod_frac_calc.sv
`timescale 1ns/1ps
module lod_frac_calc
    import lod_pkg::*;
(
    input  logic [VAL_W-1:0] val_i,
    input  logic [POS_W-1:0] pos_i,
    output logic [WGT_W-1:0] frac_o
);
    logic [POS_W-1:0] eff;

    // bits just below the leading one, left aligned; below 1.0 the
    // 1.0 position acts as the reference
    always_comb begin
        eff = (pos_i < POS_W'(FRAC_BITS)) ? POS_W'(FRAC_BITS) : pos_i;
        frac_o = '0;
        for (int j = 0; j < WGT_W; j++) begin
            int k;
            k = int'(eff) - WGT_W + j;
            if (k >= 0 && k < VAL_W) frac_o[j] = val_i[k];
        end
    end
endmodule

// File: rtl/lod_strobe_pipe.sv
`timescale 1ns/1ps
module lod_strobe_pipe
    import lod_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic span_start,
    input  logic two_cycle,
    output logic load_d3,
    output logic load_d4,
    output logic cycle
);
    strobe_t st_d, st_q;

    always_comb begin
        st_d.sr = {st_q.sr[TAP_LATE-2:0], load};
        if (span_start) begin
            st_d.cyc = 1'b0;
        end else if (two_cycle) begin
            st_d.cyc = ~st_q.cyc;
        end else begin
            st_d.cyc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_d3 = st_q.sr[TAP_EARLY-1];
    assign load_d4 = st_q.sr[TAP_LATE-1];
    assign cycle   = st_q.cyc;
endmodule

// File: rtl/lod_calc_top.sv
`timescale 1ns/1ps
module lod_calc_top
    import lod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOD_W-1:0] lod_in,
    input  logic [VAL_W-1:0] min_level,
    input  logic [LVL_W-1:0] max_level,
    input  logic [LVL_W-1:0] prim_tile,
    input  logic             lod_en,
    input  logic             sharpen_en,
    input  logic             detail_en,
    input  logic             load,
    input  logic             span_start,
    input  logic             two_cycle,
    output logic [LVL_W-1:0] tile_out,
    output logic [WGT_W-1:0] frac_out,
    output logic             lod_ge_one,
    output logic             load_d3,
    output logic             load_d4,
    output logic             cycle
);
    logic [VAL_W-1:0] cl_val;
    logic [POS_W-1:0] cl_pos;
    logic [IDX_W-1:0] idx_c;
    logic [WGT_W-1:0] raw_frac;
    logic [WGT_W-1:0] held_frac;
    logic [LVL_W-1:0] sel_lvl;

    stage1_t s1_d, s1_q;
    result_t res_d, res_q;

    lod_clamp_norm u_clamp (
        .lod_in    (lod_in),
        .min_level (min_level),
        .val_o     (cl_val),
        .pos_o     (cl_pos)
    );

    // stage 1: limit, locate level, raise flags
    always_comb begin
        idx_c = (cl_pos >= POS_W'(FRAC_BITS)) ? IDX_W'(cl_pos - POS_W'(FRAC_BITS)) : '0;
        s1_d.val    = cl_val;
        s1_d.pos    = cl_pos;
        s1_d.idx    = idx_c[LVL_W-1:0];
        s1_d.min_f  = (cl_val < ONE_VAL);
        s1_d.max_f  = (cl_val >= MAG_LIMIT) || (idx_c >= IDX_W'(max_level));
        s1_d.lvl    = max_level;
        s1_d.prim   = prim_tile;
        s1_d.lod_en = lod_en;
        s1_d.sharp  = sharpen_en;
        s1_d.det    = detail_en;
    end

    lod_frac_calc u_frac (
        .val_i  (s1_q.val),
        .pos_i  (s1_q.pos),
        .frac_o (raw_frac)
    );

    // stage 2: select level, shape the weight, pick the tile
    always_comb begin
        sel_lvl = s1_q.max_f ? s1_q.lvl : s1_q.idx;

        held_frac = raw_frac;
        if (!s1_q.sharp && !s1_q.det) begin
            if (s1_q.min_f) held_frac = '0;
            if (s1_q.max_f) held_frac = '1;
        end

        res_d.frac = (s1_q.min_f && s1_q.sharp) ? (~held_frac + WGT_W'(1)) : held_frac;
        res_d.tile = s1_q.lod_en ? (s1_q.prim + sel_lvl) : s1_q.prim;
        res_d.ge1  = (s1_q.val >= ONE_VAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= '0;
            res_q <= '0;
        end else begin
            s1_q  <= s1_d;
            res_q <= res_d;
        end
    end

    assign tile_out   = res_q.tile;
    assign frac_out   = res_q.frac;
    assign lod_ge_one = res_q.ge1;

    lod_strobe_pipe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .span_start (span_start),
        .two_cycle  (two_cycle),
        .load_d3    (load_d3),
        .load_d4    (load_d4),
        .cycle      (cycle)
    );
endmodule

// File: rtl/lod_calc_chk.sv
`timescale 1ns/1ps
module lod_calc_chk
    import lod_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LOD_W-1:0] lod_in,
    input logic [VAL_W-1:0] min_level,
    input logic [LVL_W-1:0] prim_tile,
    input logic             lod_en,
    input logic             load,
    input logic             span_start,
    input logic             two_cycle,
    input logic [LVL_W-1:0] tile_out,
    input logic             lod_ge_one,
    input logic             load_d3,
    input logic             load_d4,
    input logic             cycle
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    p_tap_three_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (load_d3 == $past(load, 3)));

    p_tap_four_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5) |-> (load_d4 == $past(load, 4)));

    p_span_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        span_start |=> !cycle);

    p_single_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !two_cycle |=> !cycle);

    p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (two_cycle && !span_start) |=> (cycle != $past(cycle)));

    p_bypass_tile_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd3) && !$past(lod_en, 2)) |-> (tile_out == $past(prim_tile, 2)));

    p_below_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd3) && ($signed($past(lod_in, 2)) < 17'sd32)
         && ($past(min_level, 2) < 15'd32)) |-> !lod_ge_one);
endmodule

bind lod_calc_top lod_calc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lod_in     (lod_in),
    .min_level  (min_level),
    .prim_tile  (prim_tile),
    .lod_en     (lod_en),
    .load       (load),
    .span_start (span_start),
    .two_cycle  (two_cycle),
    .tile_out   (tile_out),
    .lod_ge_one (lod_ge_one),
    .load_d3    (load_d3),
    .load_d4    (load_d4),
    .cycle      (cycle)
);

// File: tb/sim_lod_calc_top.sv
`timescale 1ns/1ps
module sim_lod_calc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] lod_in = '0;
    logic [14:0] min_level = '0;
    logic [2:0]  max_level = '0;
    logic [2:0]  prim_tile = '0;
    logic        lod_en = 1'b0, sharpen_en = 1'b0, detail_en = 1'b0;
    logic        load = 1'b0, span_start = 1'b0, two_cycle = 1'b0;
    logic [2:0]  tile_out;
    logic [7:0]  frac_out;
    logic        lod_ge_one, load_d3, load_d4, cycle;

    lod_calc_top u0 (.*);

    always #5 clk = ~clk;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    int c_minl, c_maxl, c_prim, c_en, c_sh, c_dt, c_two;
    int e0_t, e0_f, e0_g, e1_t, e1_f, e1_g;
    bit vld0 = 1'b0, vld1 = 1'b0;
    bit [3:0] h_load = '0;
    bit h_span = 1'b0, h_two = 1'b0, ecyc = 1'b0;
    logic [15:0] lf = 16'hACE1;

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic void model(input int l, input int minl, input int maxl,
                                  input int prim, input int en, input int sh,
                                  input int dt, output int t, output int f,
                                  output int g);
        int v;
        int i;
        bit mn;
        bit mx;
        int ci;
        if (l > 32767) v = 32767;
        else if (l < 0 || l < minl) v = minl;
        else v = l;
        i = 0;
        while (v >= (64 << i)) i++;
        mn = (v < 32);
        mx = (v >= 8192) || (i >= maxl);
        ci = mx ? maxl : i;
        f = ((v * 8) >> i) & 255;
        if (sh == 0 && dt == 0) begin
            if (mn) f = 0;
            if (mx) f = 255;
        end
        if (mn && sh != 0) f = (256 - f) & 255;
        t = (en != 0) ? ((prim + ci) % 8) : prim;
        g = (v >= 32) ? 1 : 0;
    endfunction

    task automatic step(input int l);
        bit ld;
        bit sp;
        @(negedge clk);
        if (vld1) begin
            chk("R2 R3 R7 R11 tile", int'(tile_out), e1_t);
            chk("R1 R4 R5 R6 R11 frac", int'(frac_out), e1_f);
            chk("R8 R11 ge_one", int'(lod_ge_one), e1_g);
        end
        chk("R9 load_d3", int'(load_d3), int'(h_load[2]));
        chk("R9 load_d4", int'(load_d4), int'(h_load[3]));
        ecyc = h_span ? 1'b0 : (h_two ? ~ecyc : 1'b0);
        chk("R10 cycle", int'(cycle), int'(ecyc));

        e1_t = e0_t; e1_f = e0_f; e1_g = e0_g; vld1 = vld0;
        model(l, c_minl, c_maxl, c_prim, c_en, c_sh, c_dt, e0_t, e0_f, e0_g);
        vld0 = 1'b1;

        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ld = lf[0];
        sp = (lf[5:3] == 3'b000);
        h_load = {h_load[2:0], ld};
        h_span = sp;
        h_two = (c_two != 0);

        lod_in     = 17'(l);
        min_level  = 15'(c_minl);
        max_level  = 3'(c_maxl);
        prim_tile  = 3'(c_prim);
        lod_en     = (c_en != 0);
        sharpen_en = (c_sh != 0);
        detail_en  = (c_dt != 0);
        load       = ld;
        span_start = sp;
        two_cycle  = (c_two != 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #1900000;
        total++;
        fails++;
        $display("FAIL watchdog: got %0h expected %0h", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: everything low while reset is held
        chk("R12 tile reset", int'(tile_out), 0);
        chk("R12 frac reset", int'(frac_out), 0);
        chk("R12 ge_one reset", int'(lod_ge_one), 0);
        chk("R12 d3 reset", int'(load_d3), 0);
        chk("R12 d4 reset", int'(load_d4), 0);
        chk("R12 cycle reset", int'(cycle), 0);
        rst_n = 1'b1;

        for (int c = 0; c < 8; c++) begin
            case (c)
                0: c_minl = 0;
                1: c_minl = 0;
                2: c_minl = 'h10;
                3: c_minl = 'h40;
                4: c_minl = 'h4;
                5: c_minl = 'h100;
                6: c_minl = 0;
                default: c_minl = 'h21;
            endcase
            case (c)
                0: c_maxl = 7;
                1: c_maxl = 3;
                2: c_maxl = 5;
                3: c_maxl = 2;
                4: c_maxl = 0;
                5: c_maxl = 7;
                6: c_maxl = 6;
                default: c_maxl = 1;
            endcase
            c_prim = (c * 5 + 3) % 8;
            c_en   = (c == 2 || c == 6) ? 0 : 1;
            c_sh   = c & 1;
            c_dt   = (c >> 1) & 1;
            c_two  = (c >> 2) & 1;
            for (int l = -300; l <= 65535; l += 13) step(l);
            step(0); step(31); step(32); step(63); step(64);
            step('h1fff); step('h2000); step('h7fff); step('h8000);
            step('hffff); step(-1); step(-65536);
        end
        repeat (3) step(0);
        summary();
    end
endmodule